// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is one switching node of a two-dimensional mesh. It has five bidirectional ports: the local block plus the north, east, south and west neighbours. Flits that arrive on an input go into a small per-input queue. The first flit of a packet names a destination grid point. The router sends it along X until the column matches, then along Y, and delivers it locally when both coordinates match.

An output won by a packet's first flit stays reserved for that input until the last flit has gone through. Flits of other packets that want the same output wait, even while the reserved packet is stalled. Each output counts the free slots in the neighbour's queue. It sends nothing when that count is zero. Each input hands a credit back upstream for every flit it drains.

Routing, arbitration and crossbar traversal take one cycle, and all outputs are registered.

Top module: `mesh_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every `out_valid` bit and every `in_credit` bit is 0.
- R2: A flit type is coded in bits [15:14]: 00 body, 01 first, 10 last, 11 single-flit packet. The destination X is in bits [13:11] and the destination Y in bits [10:8]. A packet's first flit whose destination X is greater than the router's X leaves on east (port index 2). If the destination X is smaller, it leaves on west (index 4). This holds regardless of Y.
- R3: When the destination X equals the router's X, a destination Y greater than its own leaves on north (index 1), and a smaller one leaves on south (index 3).
- R4: When both coordinates match, the packet leaves on local (index 0).
- R5: Body and last flits follow the output reserved by their first flit. That output is held until the last flit is sent, including through idle input cycles. Another input's packet for that output leaves only after the last flit.
- R6: A single-flit packet does not keep its output. A different input's packet can use that output in the very next cycle.
- R7: Each output starts with FIFO_DEPTH credits. It spends one per flit sent and gains one per `out_credit` pulse. It sends no flit while its count is zero.
- R8: When several inputs hold first flits for the same free output, the output serves them in round-robin order. After reset, the lowest index is served first.
- R9: `in_credit[i]` pulses for one cycle per flit drained from input i. The pulse comes in the same cycle that flit appears on its output.
- R10: A flit presented at clock edge k appears on its output after edge k+1, when the path is free and credits are available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per-input flit strobe |
| in_flit | input | 5x16 | Per-input flit data |
| in_credit | output | 5 | Per-input credit returned upstream |
| out_valid | output | 5 | Per-output flit strobe |
| out_flit | output | 5x16 | Per-output flit data |
| out_credit | input | 5 | Per-output credit from the downstream neighbour |

## Verification
A reservation that is dropped too early lets another input's flit land inside a packet on the very next output cycle. A reservation that is never dropped shows up as an output that goes silent for good after a last flit. A credit count off by one shows up as a fifth flit sent with no credit, or as one flit too few, in the cycles right after the neighbour stops returning credits. A wrong route or a wrong arbiter pointer shows up within two cycles, as a flit on the wrong port or in the wrong order.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int NPORT   = 5;
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_SOUTH = 3;
  localparam int P_WEST  = 4;
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_FIRST = 2'b01,
    FK_LAST = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill;

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      fill <= fill + CW'(wr_en) - CW'(rd_en);
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst) !(wr_en && full && !rd_en));
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty);
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] grant_idx
);
  localparam int PW = $clog2(N);

  logic [PW-1:0] last;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (grant == '0 && req[(int'(last) + k) % N]) begin
        grant[(int'(last) + k) % N] = 1'b1;
        grant_idx = PW'((int'(last) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= PW'(N - 1);
    else if (|grant) last <= grant_idx;
  end

  a_r8_rotate: assert property (@(posedge clk) disable iff (rst)
    ((|grant) && (|(req & ~grant))) |=> (!$stable(req) || grant != $past(grant)));
  a_r8_grant_single: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mrt_pkg::*;
#(
  parameter int X_POS      = 2,
  parameter int Y_POS      = 2,
  parameter int COORD_W    = 3,
  parameter int FLIT_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NPORT-1:0]                   in_valid,
  input  logic [NPORT-1:0][FLIT_W-1:0]       in_flit,
  output logic [NPORT-1:0]                   in_credit,
  output logic [NPORT-1:0]                   out_valid,
  output logic [NPORT-1:0][FLIT_W-1:0]       out_flit,
  input  logic [NPORT-1:0]                   out_credit
);
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W   = $clog2(NPORT);
  localparam int END_BIT = FLIT_W - 1;
  localparam int BEG_BIT = FLIT_W - 2;
  localparam int DX_LSB  = FLIT_W - 2 - COORD_W;
  localparam int DY_LSB  = DX_LSB - COORD_W;

  logic [FLIT_W-1:0] fr_data [NPORT];
  logic [NPORT-1:0]  fr_empty, fr_full, pop;
  logic [NPORT-1:0]  head_req [NPORT];
  logic [NPORT-1:0]  arb_req  [NPORT];
  logic [NPORT-1:0]  arb_gnt  [NPORT];
  logic [IDX_W-1:0]  arb_idx  [NPORT];
  logic [IDX_W-1:0]  src      [NPORT];
  logic [IDX_W-1:0]  lock_src [NPORT];
  logic [NPORT-1:0]  lock_v, send;
  logic [FLIT_W-1:0] sflit    [NPORT];
  logic [CNT_W-1:0]  cnt      [NPORT];

  function automatic logic [IDX_W-1:0] route_of(input logic [FLIT_W-1:0] f);
    logic [COORD_W-1:0] dx, dy;
    dx = f[DX_LSB +: COORD_W];
    dy = f[DY_LSB +: COORD_W];
    if (dx > COORD_W'(X_POS))      return IDX_W'(P_EAST);
    else if (dx < COORD_W'(X_POS)) return IDX_W'(P_WEST);
    else if (dy > COORD_W'(Y_POS)) return IDX_W'(P_NORTH);
    else if (dy < COORD_W'(Y_POS)) return IDX_W'(P_SOUTH);
    else                           return IDX_W'(P_LOCAL);
  endfunction

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    flit_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_q (
      .clk(clk), .rst(rst),
      .wr_en(in_valid[i]), .wr_data(in_flit[i]),
      .rd_en(pop[i]), .rd_data(fr_data[i]),
      .empty(fr_empty[i]), .full(fr_full[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) head_req[o] = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (!fr_empty[i] && fr_data[i][BEG_BIT])
        head_req[route_of(fr_data[i])][i] = 1'b1;
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    assign arb_req[o] = (lock_v[o] || cnt[o] == '0) ? '0 : head_req[o];

    rr_arbiter #(.N(NPORT)) u_arb (
      .clk(clk), .rst(rst), .req(arb_req[o]),
      .grant(arb_gnt[o]), .grant_idx(arb_idx[o])
    );

    assign src[o]   = lock_v[o] ? lock_src[o] : arb_idx[o];
    assign send[o]  = lock_v[o] ? (!fr_empty[lock_src[o]] && cnt[o] != '0) : (|arb_gnt[o]);
    assign sflit[o] = fr_data[src[o]];

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_v[o]   <= 1'b0;
        lock_src[o] <= '0;
        cnt[o]      <= CNT_W'(FIFO_DEPTH);
        out_valid[o] <= 1'b0;
        out_flit[o]  <= '0;
      end else begin
        if (send[o]) begin
          lock_v[o] <= !sflit[o][END_BIT];
          if (!lock_v[o]) lock_src[o] <= src[o];
        end
        cnt[o]       <= cnt[o] - CNT_W'(send[o]) + CNT_W'(out_credit[o]);
        out_valid[o] <= send[o];
        out_flit[o]  <= sflit[o];
      end
    end

    a_r5_lock_hold: assert property (@(posedge clk) disable iff (rst)
      (lock_v[o] && !send[o]) |=> (lock_v[o] && lock_src[o] == $past(lock_src[o])));
    a_r6_solo_free: assert property (@(posedge clk) disable iff (rst)
      (send[o] && !lock_v[o] && sflit[o][END_BIT]) |=> !lock_v[o]);
    a_r7_credit_gate: assert property (@(posedge clk) disable iff (rst) send[o] |-> cnt[o] != '0);
    a_r7_credit_cap: assert property (@(posedge clk) disable iff (rst) cnt[o] <= CNT_W'(FIFO_DEPTH));
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++)
      if (send[o]) pop[src[o]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) in_credit <= '0;
    else     in_credit <= pop;
  end
endmodule

// File: tb/mesh_router_tb.sv
module mesh_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int L = 0, N = 1, E = 2, S = 3, W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] in_valid = '0;
  logic [NP-1:0][15:0] in_flit = '0;
  logic [NP-1:0] in_credit, out_valid;
  logic [NP-1:0][15:0] out_flit;
  logic [NP-1:0] out_credit, man_credit = '0, auto_ret = '0;
  logic auto_en = 1'b1;

  int tests = 0, fails = 0;
  int cyc = 0;
  int rec_n [NP];
  int cred_n [NP];
  logic [7:0] rec_pl [NP][32];
  int rec_cy [NP][32];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign out_credit = auto_ret | man_credit;

  mesh_router u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .in_credit(in_credit), .out_valid(out_valid), .out_flit(out_flit),
    .out_credit(out_credit)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    auto_ret <= auto_en ? out_valid : '0;
    for (int p = 0; p < NP; p++) begin
      if (rst) begin
        rec_n[p] = 0;
        cred_n[p] = 0;
      end else begin
        if (out_valid[p] && rec_n[p] < 32) begin
          rec_pl[p][rec_n[p]] = out_flit[p][7:0];
          rec_cy[p][rec_n[p]] = cyc;
          rec_n[p] = rec_n[p] + 1;
        end
        if (in_credit[p]) cred_n[p] = cred_n[p] + 1;
      end
    end
  end

  function automatic logic [15:0] mk(input logic [1:0] k, input int dx, input int dy, input logic [7:0] pl);
    return {k, 3'(dx), 3'(dy), pl};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = '0; man_credit = '0; auto_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input int p, input logic [15:0] f);
    in_valid[p] = 1'b1;
    in_flit[p] = f;
  endtask

  task automatic tick();
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_credit in reset", int'(in_credit), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_credit after reset", int'(in_credit), 0);
  endtask

  task automatic route_one(input string req, input int inp, input int dx, input int dy, input int exp_port, input logic [7:0] pl);
    do_reset();
    drive(inp, mk(2'b11, dx, dy, pl));
    tick();
    idle(4);
    chk(req, rec_n[exp_port], 1);
    chk(req, int'(rec_pl[exp_port][0]), int'(pl));
  endtask

  task automatic t_route();
    route_one("R2 east even with lower Y", L, 3, 1, E, 8'h31);
    route_one("R2 west even with higher Y", L, 0, 3, W, 8'h32);
    route_one("R3 north", L, 2, 3, N, 8'h33);
    route_one("R3 south", L, 2, 0, S, 8'h34);
    route_one("R4 local", N, 2, 2, L, 8'h35);
  endtask

  task automatic t_latency();
    do_reset();
    drive(L, mk(2'b11, 4, 2, 8'h5A));
    tick();
    chk("R10 not yet out", int'(out_valid[E]), 0);
    @(negedge clk);
    chk("R10 out after second edge", int'(out_valid[E]), 1);
    chk("R10 payload", int'(out_flit[E][7:0]), 8'h5A);
    chk("R9 credit with flit", int'(in_credit[L]), 1);
    @(negedge clk);
    chk("R9 credit one cycle", int'(in_credit[L]), 0);
  endtask

  task automatic t_worm();
    do_reset();
    drive(W, mk(2'b01, 3, 2, 8'h11));
    tick();
    drive(W, mk(2'b00, 0, 0, 8'h22));
    drive(S, mk(2'b11, 4, 2, 8'h99));
    tick();
    idle(2);
    drive(W, mk(2'b10, 0, 0, 8'h33));
    tick();
    idle(5);
    chk("R5 east count", rec_n[E], 4);
    chk("R5 first", int'(rec_pl[E][0]), 8'h11);
    chk("R5 body follows", int'(rec_pl[E][1]), 8'h22);
    chk("R5 last before other", int'(rec_pl[E][2]), 8'h33);
    chk("R5 other after last", int'(rec_pl[E][3]), 8'h99);
  endtask

  task automatic t_solo();
    do_reset();
    drive(L, mk(2'b11, 5, 2, 8'h41));
    drive(N, mk(2'b11, 5, 2, 8'h42));
    tick();
    idle(4);
    chk("R6 both out", rec_n[E], 2);
    chk("R6 back to back", rec_cy[E][1] - rec_cy[E][0], 1);
  endtask

  task automatic t_rr();
    do_reset();
    drive(N, mk(2'b11, 2, 2, 8'hA0));
    drive(S, mk(2'b11, 2, 2, 8'hB0));
    tick();
    drive(N, mk(2'b11, 2, 2, 8'hA1));
    drive(S, mk(2'b11, 2, 2, 8'hB1));
    tick();
    idle(6);
    chk("R8 count", rec_n[L], 4);
    chk("R8 order 0", int'(rec_pl[L][0]), 8'hA0);
    chk("R8 order 1", int'(rec_pl[L][1]), 8'hB0);
    chk("R8 order 2", int'(rec_pl[L][2]), 8'hA1);
    chk("R8 order 3", int'(rec_pl[L][3]), 8'hB1);
  endtask

  task automatic t_credit();
    do_reset();
    auto_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      drive(L, mk(2'b11, 6, 2, 8'(8'h60 + k)));
      tick();
    end
    idle(4);
    drive(W, mk(2'b11, 6, 2, 8'h70));
    tick();
    drive(W, mk(2'b11, 6, 2, 8'h71));
    tick();
    idle(8);
    chk("R7 stops at zero credit", rec_n[E], 4);
    chk("R9 local credits", cred_n[L], 4);
    chk("R9 blocked input no credit", cred_n[W], 0);
    man_credit[E] = 1'b1;
    @(negedge clk);
    man_credit[E] = 1'b0;
    idle(5);
    chk("R7 one credit one flit", rec_n[E], 5);
    chk("R9 west credit", cred_n[W], 1);
    man_credit[E] = 1'b1;
    @(negedge clk);
    man_credit[E] = 1'b0;
    idle(5);
    chk("R7 second credit", rec_n[E], 6);
    chk("R7 last payload", int'(rec_pl[E][5]), 8'h71);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      rec_n[p] = 0;
      cred_n[p] = 0;
    end
    t_reset();
    t_route();
    t_latency();
    t_worm();
    t_solo();
    t_rr();
    t_credit();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule